// File: doc/BRIEF.md
# DMA Control-Port Register Unit

This block is the control plane of a four-channel DMA controller. It decodes byte-wide writes and reads on eight control ports. It keeps a command byte, one mode byte per channel, a per-channel mask nibble and an 8-bit status byte. The low status nibble holds terminal-count flags and the high nibble holds pending-request flags. Software sets and clears the request flags through a port. Per-channel hold and release inputs from peripherals also set and clear them.

The block tells the channel register block when to reset its byte-lane toggle, through `ff_clear`. It tells the transfer scheduler to re-evaluate channels, through `run_req`. Both are one-cycle pulses driven by a small state machine. The state register records, at each clock edge, which events the cycle just accepted. The states are:
- `S_IDLE`: no pulse.
- `S_KICK`: `run_req` only.
- `S_FFCLR`: `ff_clear` only.
- `S_BOTH`: both pulses.

From every state the next state is chosen by two conditions of the current cycle:
- toggle-reset: a write to port 4 or 5.
- kick: a write to port 1, 2, 6 or 7, or any hold or release input.

The transitions are:
- neither condition: go to `S_IDLE`.
- kick only: go to `S_KICK`.
- toggle-reset only: go to `S_FFCLR`.
- both conditions: go to `S_BOTH`.

Mode, mask, status and command values are exposed continuously to the scheduler.

Top module: `dmac_ctl_unit`

## Requirements
- R1: After reset, mask_o is 4'hF and status_o, cmd_o, mode_o, rd_data, run_req and ff_clear are all zero.
- R2: A write to port 0 stores wr_data into cmd_o only when the value is 8'h00 or has no bit set other than bit 2 (8'h04). Any other value leaves cmd_o unchanged.
- R3: A write to port 1 selects channel c = wr_data[1:0]. It sets status bit c+4 to wr_data[2] and clears status bit c.
- R4: A write to port 2 sets mask bit wr_data[1:0] to wr_data[2]. The other mask bits are unchanged.
- R5: A write to port 3 stores the whole byte into the mode of channel wr_data[1:0]. mode_o carries channel n in bits [8n+7:8n].
- R6: A write to port 4 produces a single-cycle ff_clear pulse in the cycle after the write, and changes no register.
- R7: A write to port 5 sets mask_o to 4'hF and zeroes status_o and cmd_o. It keeps the modes and pulses ff_clear in the next cycle. This clearing overrides every other status update in that cycle.
- R8: A write to port 6 clears all mask bits. A write to port 7 loads the mask from wr_data[3:0].
- R9: A read returns its value on rd_data in the cycle after rd_en, and rd_data is 0 after a cycle with no read. Port 0 returns the status before the read and then clears status bits [3:0] but not [7:4]. Port 1 returns {4'b0, mask}. Every other port returns 0.
- R10: run_req pulses for one cycle in the cycle after a write to port 1, 2, 6 or 7, or after any cycle with a nonzero hold_req or release_req.
- R11: hold_req[n] sets status bit n+4 and release_req[n] clears it. Both apply after a same-cycle port 1 write, and release wins over hold.
- R12: tc_done[n] sets status bit n and wins over a same-cycle status-read clear or port 1 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe for the selected port |
| port_sel | input | 3 | Control port index |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| hold_req | input | 4 | Per-channel external request assert |
| release_req | input | 4 | Per-channel external request withdraw |
| tc_done | input | 4 | Per-channel terminal count reached |
| ff_clear | output | 1 | Pulse to clear the byte-lane toggle |
| run_req | output | 1 | Pulse asking the scheduler to re-evaluate |
| mode_o | output | 32 | Packed channel mode bytes |
| mask_o | output | 4 | Channel mask bits |
| status_o | output | 8 | Request flags [7:4], terminal-count flags [3:0] |
| cmd_o | output | 8 | Command byte |

## Verification
The hardest situation to reach is a single cycle in which several sources change the same status bit. Examples are a status read, a port 1 write, a terminal-count event and a hold or release, all aimed at one channel in one cycle. Random stimulus raises the external inputs sparsely while it writes and reads random ports. Directed cycles then force the exact collisions: a read with tc_done, hold with release, and master clear with hold. A bench model applies the stated priority order in each of these cases.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        P_CMD     = 3'd0,
        P_REQ     = 3'd1,
        P_SMASK   = 3'd2,
        P_MODE    = 3'd3,
        P_FFCLR   = 3'd4,
        P_MCLR    = 3'd5,
        P_UNMASK  = 3'd6,
        P_MASKALL = 3'd7
    } ctl_port_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_KICK  = 2'd1,
        S_FFCLR = 2'd2,
        S_BOTH  = 2'd3
    } pulse_st_t;

    localparam logic [7:0] CMD_ALLOWED = 8'h04;

    function automatic logic cmd_ok(input logic [7:0] v);
        return (v == 8'h00) || ((v & ~CMD_ALLOWED) == 8'h00);
    endfunction

endpackage

// File: rtl/dmac_mode_bank.sv
module dmac_mode_bank #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [CHW-1:0]      sel,
    input  logic [DW-1:0]       din,
    output logic [NCH*DW-1:0]   modes_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_mode
        logic [DW-1:0] mode_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q <= '0;
            else if (we && (sel == CHW'(g)))
                mode_q <= din;
        end
        assign modes_o[g*DW +: DW] = mode_q;
    end

endmodule

// File: rtl/dmac_chan_state.sv
module dmac_chan_state #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mclr,
    input  logic                rd_clr_tc,
    input  logic                req_we,
    input  logic [CHW-1:0]      req_ch,
    input  logic                req_val,
    input  logic                smask_we,
    input  logic [CHW-1:0]      smask_ch,
    input  logic                smask_val,
    input  logic                unmask_all,
    input  logic                mask_load,
    input  logic [NCH-1:0]      mask_din,
    input  logic [NCH-1:0]      hold,
    input  logic [NCH-1:0]      rel,
    input  logic [NCH-1:0]      tc,
    output logic [NCH-1:0]      mask_o,
    output logic [2*NCH-1:0]    status_o
);

    logic [NCH-1:0] rq_q, tc_q;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hit_req, hit_mask;
        logic rq_d, tc_d, mk_d;
        logic mk_q;

        assign hit_req  = req_we   && (req_ch   == CHW'(g));
        assign hit_mask = smask_we && (smask_ch == CHW'(g));

        always_comb begin
            rq_d = rq_q[g];
            if (hit_req) rq_d = req_val;
            if (hold[g]) rq_d = 1'b1;
            if (rel[g])  rq_d = 1'b0;

            tc_d = tc_q[g];
            if (rd_clr_tc || hit_req) tc_d = 1'b0;
            if (tc[g]) tc_d = 1'b1;

            mk_d = mk_q;
            if (hit_mask)        mk_d = smask_val;
            else if (unmask_all) mk_d = 1'b0;
            else if (mask_load)  mk_d = mask_din[g];
        end

        always_ff @(posedge clk) begin
            if (!rst_n || mclr) begin
                rq_q[g] <= 1'b0;
                tc_q[g] <= 1'b0;
                mk_q    <= 1'b1;
            end else begin
                rq_q[g] <= rq_d;
                tc_q[g] <= tc_d;
                mk_q    <= mk_d;
            end
        end

        assign mask_o[g] = mk_q;
    end

    assign status_o = {rq_q, tc_q};

endmodule

// File: rtl/dmac_ctl_unit.sv
module dmac_ctl_unit #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CHW = $clog2(NCH),
    localparam int PW  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [PW-1:0]       port_sel,
    input  logic [DW-1:0]       wr_data,
    output logic [DW-1:0]       rd_data,
    input  logic [NCH-1:0]      hold_req,
    input  logic [NCH-1:0]      release_req,
    input  logic [NCH-1:0]      tc_done,
    output logic                ff_clear,
    output logic                run_req,
    output logic [NCH*DW-1:0]   mode_o,
    output logic [NCH-1:0]      mask_o,
    output logic [2*NCH-1:0]    status_o,
    output logic [DW-1:0]       cmd_o
);
    import dmac_pkg::*;

    ctl_port_t port;
    assign port = ctl_port_t'(port_sel);

    logic wr_cmd, wr_req, wr_smask, wr_mode, wr_ffclr, wr_mclr, wr_unmask, wr_mload;
    assign wr_cmd    = wr_en && (port == P_CMD);
    assign wr_req    = wr_en && (port == P_REQ);
    assign wr_smask  = wr_en && (port == P_SMASK);
    assign wr_mode   = wr_en && (port == P_MODE);
    assign wr_ffclr  = wr_en && (port == P_FFCLR);
    assign wr_mclr   = wr_en && (port == P_MCLR);
    assign wr_unmask = wr_en && (port == P_UNMASK);
    assign wr_mload  = wr_en && (port == P_MASKALL);

    logic rd_status;
    assign rd_status = rd_en && (port == P_CMD);

    dmac_mode_bank #(.NCH(NCH), .DW(DW)) u_modes (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_mode),
        .sel     (wr_data[CHW-1:0]),
        .din     (wr_data),
        .modes_o (mode_o)
    );

    dmac_chan_state #(.NCH(NCH)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .mclr       (wr_mclr),
        .rd_clr_tc  (rd_status),
        .req_we     (wr_req),
        .req_ch     (wr_data[CHW-1:0]),
        .req_val    (wr_data[CHW]),
        .smask_we   (wr_smask),
        .smask_ch   (wr_data[CHW-1:0]),
        .smask_val  (wr_data[CHW]),
        .unmask_all (wr_unmask),
        .mask_load  (wr_mload),
        .mask_din   (wr_data[NCH-1:0]),
        .hold       (hold_req),
        .rel        (release_req),
        .tc         (tc_done),
        .mask_o     (mask_o),
        .status_o   (status_o)
    );

    // Command register
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr)
            cmd_o <= '0;
        else if (wr_cmd && cmd_ok(wr_data))
            cmd_o <= wr_data;
    end

    // Read path, registered
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en) begin
            unique case (port)
                P_CMD:   rd_data <= DW'(status_o);
                P_REQ:   rd_data <= DW'(mask_o);
                default: rd_data <= '0;
            endcase
        end else
            rd_data <= '0;
    end

    // Pulse state machine
    pulse_st_t state_q, state_d;
    logic      kick, toggle_rst;

    assign kick       = wr_req || wr_smask || wr_unmask || wr_mload
                        || (|hold_req) || (|release_req);
    assign toggle_rst = wr_ffclr || wr_mclr;

    always_comb begin
        unique case ({toggle_rst, kick})
            2'b00:   state_d = S_IDLE;
            2'b01:   state_d = S_KICK;
            2'b10:   state_d = S_FFCLR;
            default: state_d = S_BOTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run_req  = 1'b0;
        ff_clear = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_KICK:  run_req = 1'b1;
            S_FFCLR: ff_clear = 1'b1;
            S_BOTH: begin
                run_req  = 1'b1;
                ff_clear = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dmac_ctl_chk.sv
module dmac_ctl_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [2:0]          port_sel,
    input logic [DW-1:0]       wr_data,
    input logic [DW-1:0]       rd_data,
    input logic [NCH-1:0]      hold_req,
    input logic [NCH-1:0]      release_req,
    input logic [NCH-1:0]      tc_done,
    input logic                ff_clear,
    input logic                run_req,
    input logic [NCH*DW-1:0]   mode_o,
    input logic [NCH-1:0]      mask_o,
    input logic [2*NCH-1:0]    status_o,
    input logic [DW-1:0]       cmd_o
);

    // R7
    mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_sel == 3'd5) |=> (mask_o == '1 && status_o == '0 && cmd_o == '0 && ff_clear));

    // R6
    ffclr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_sel == 3'd4) |=> ff_clear);

    // R2
    cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_sel == 3'd0 && wr_data != 8'h00 && wr_data != 8'h04) |=> $stable(cmd_o));

    // R9
    mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 3'd1) |=> (rd_data == DW'($past(mask_o))));

    // R9
    tc_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 3'd0 && !wr_en && tc_done == '0) |=> (status_o[NCH-1:0] == '0));

    // R10
    run_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hold_req != '0) || (release_req != '0)) |=> run_req);

    // R12
    tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_done != '0 && !(wr_en && port_sel == 3'd5)) |=> ((status_o[NCH-1:0] & $past(tc_done)) == $past(tc_done)));

endmodule

bind dmac_ctl_unit dmac_ctl_chk #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/test_dmac_ctl_unit.sv
module test_dmac_ctl_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  port_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  hold_req = '0, release_req = '0, tc_done = '0;
    logic        ff_clear, run_req;
    logic [31:0] mode_o;
    logic [3:0]  mask_o;
    logic [7:0]  status_o, cmd_o;

    always #5 clk = ~clk;

    dmac_ctl_unit i_dmac_ctl_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .port_sel(port_sel), .wr_data(wr_data), .rd_data(rd_data),
        .hold_req(hold_req), .release_req(release_req), .tc_done(tc_done),
        .ff_clear(ff_clear), .run_req(run_req), .mode_o(mode_o),
        .mask_o(mask_o), .status_o(status_o), .cmd_o(cmd_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] m_mask;
    logic [7:0] m_status, m_cmd;
    logic [7:0] m_mode [4];

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(logic we, logic re, logic [2:0] p,
                                     logic [3:0] h, logic [3:0] r, logic [3:0] t);
        if (we) begin
            case (p)
                3'd0: return "R2";
                3'd1: return "R3";
                3'd2: return "R4";
                3'd3: return "R5";
                3'd4: return "R6";
                3'd5: return "R7";
                default: return "R8";
            endcase
        end
        if (re) return "R9";
        if (t != 0) return "R12";
        if (h != 0 || r != 0) return "R11";
        return "R1";
    endfunction

    function automatic logic cmd_accept(logic [7:0] v);
        return (v == 8'h00) || (v == 8'h04);
    endfunction

    // One cycle: drive at a falling edge, check at the next falling edge
    task automatic cyc(logic we, logic re, logic [2:0] p, logic [7:0] d,
                       logic [3:0] h, logic [3:0] r, logic [3:0] t);
        logic [7:0] ns;
        logic [3:0] nm;
        logic [7:0] exp_rd;
        logic exp_run, exp_ff;
        string tg;
        int ch;
        wr_en = we; rd_en = re; port_sel = p; wr_data = d;
        hold_req = h; release_req = r; tc_done = t;
        tg = tag_of(we, re, p, h, r, t);
        ch = int'(d[1:0]);
        exp_rd = 8'h00;
        if (re) exp_rd = (p == 3'd0) ? m_status : (p == 3'd1) ? {4'b0, m_mask} : 8'h00;
        exp_run = (we && (p == 3'd1 || p == 3'd2 || p == 3'd6 || p == 3'd7)) || (h != 0) || (r != 0);
        exp_ff  = we && (p == 3'd4 || p == 3'd5);
        ns = m_status; nm = m_mask;
        if (we && p == 3'd5) begin
            ns = 8'h00; nm = 4'hF; m_cmd = 8'h00;
        end else begin
            if (re && p == 3'd0) ns[3:0] = 4'h0;
            if (we && p == 3'd1) begin ns[ch+4] = d[2]; ns[ch] = 1'b0; end
            ns[7:4] = (ns[7:4] | h) & ~r;
            ns[3:0] = ns[3:0] | t;
            if (we && p == 3'd2) nm[ch] = d[2];
            if (we && p == 3'd6) nm = 4'h0;
            if (we && p == 3'd7) nm = d[3:0];
            if (we && p == 3'd0 && cmd_accept(d)) m_cmd = d;
            if (we && p == 3'd3) m_mode[ch] = d;
        end
        m_status = ns; m_mask = nm;
        @(posedge clk);
        @(negedge clk);
        chk(tg, "status", 32'(status_o), 32'(m_status));
        chk(tg, "mask", 32'(mask_o), 32'(m_mask));
        chk(tg, "cmd", 32'(cmd_o), 32'(m_cmd));
        chk(tg, "mode", mode_o, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
        chk("R9", "rd_data", 32'(rd_data), 32'(exp_rd));
        chk("R10", "run_req", 32'(run_req), 32'(exp_run));
        chk(tg, "ff_clear", 32'(ff_clear), 32'(exp_ff));
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h0);
    endtask

    initial begin
        m_mask = 4'hF; m_status = 8'h00; m_cmd = 8'h00;
        for (int i = 0; i < 4; i++) m_mode[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "mask", 32'(mask_o), 32'hF);
        chk("R1", "status", 32'(status_o), 32'h0);
        chk("R1", "cmd", 32'(cmd_o), 32'h0);
        chk("R1", "mode", mode_o, 32'h0);
        chk("R1", "rd_data", 32'(rd_data), 32'h0);
        chk("R1", "pulses", {30'b0, run_req, ff_clear}, 32'h0);

        // R2 command filter
        cyc(1, 0, 3'd0, 8'h04, 0, 0, 0);
        cyc(1, 0, 3'd0, 8'h08, 0, 0, 0);
        cyc(1, 0, 3'd0, 8'h05, 0, 0, 0);
        cyc(1, 0, 3'd0, 8'h00, 0, 0, 0);
        // R5 modes on every channel
        for (int c = 0; c < 4; c++) cyc(1, 0, 3'd3, 8'h54 | 8'(c), 0, 0, 0);
        // R8, R4 mask ops
        cyc(1, 0, 3'd6, 8'h00, 0, 0, 0);
        cyc(1, 0, 3'd2, 8'h06, 0, 0, 0);
        cyc(1, 1, 3'd1, 8'h00, 0, 0, 0);
        cyc(1, 0, 3'd7, 8'hA9, 0, 0, 0);
        cyc(0, 1, 3'd1, 8'h00, 0, 0, 0);
        // R12 tc set, R9 read clears tc only, R3 request
        cyc(1, 0, 3'd1, 8'h05, 0, 0, 4'hF);
        cyc(0, 1, 3'd0, 8'h00, 0, 0, 0);
        cyc(0, 1, 3'd0, 8'h00, 0, 0, 4'h2);
        cyc(0, 1, 3'd5, 8'h00, 0, 0, 0);
        cyc(1, 0, 3'd1, 8'h01, 0, 0, 4'h2);
        // R11 hold and release collide, release wins
        cyc(0, 0, 3'd0, 8'h00, 4'hC, 4'h4, 0);
        cyc(1, 0, 3'd1, 8'h07, 0, 4'h8, 0);
        // R6 toggle clear, R7 master clear with hold
        cyc(1, 0, 3'd4, 8'hFF, 0, 0, 0);
        cyc(1, 0, 3'd5, 8'h00, 4'h3, 0, 4'h1);
        idle();

        void'($urandom(32'd4242));
        for (int n = 0; n < 3000; n++) begin
            logic we, re;
            logic [2:0] p;
            logic [7:0] d;
            logic [3:0] h, r, t;
            we = ($urandom % 2) == 0;
            re = ($urandom % 3) == 0;
            p  = 3'($urandom % 8);
            d  = 8'($urandom);
            if (we && p == 3'd0 && ($urandom % 2) == 0) d = (($urandom % 2) == 0) ? 8'h04 : 8'h00;
            if (we && p == 3'd5 && ($urandom % 4) != 0) we = 1'b0;
            h = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
            r = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
            t = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
            cyc(we, re, p, d, h, r, t);
        end
        idle();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule